// File: doc/BRIEF.md
# Gated Pseudo-Random Test Byte Source

This block feeds a UART self-test loop with test bytes. An 8-bit maximal-length linear feedback shift register holds the current test byte. It steps to a new value only when a trigger input is accepted. The new byte appears on a parallel bus for the transmitter under test. In the same clock it is loaded into a framing serializer, which sends it as an asynchronous character on a serial line for the receiver under test.

A trigger is accepted only when the serializer is idle and the pattern budget is not used up. This keeps the parallel byte and the serialized byte the same at all times. After a fixed number of patterns the block sets a completion flag, drops its run indication and ignores all further triggers.

Top module: `bist_pattern_gen`

## Requirements
- R1: While rst is high at a clock edge, pat_data is SEED (default 8'hA5), ser_out is 1, and ser_busy, pat_valid, done and run_en are all 0.
- R2: run_en is 0 during reset. It is 1 from the first clock edge after reset is released until done rises, and 0 from then on.
- R3: A trigger is accepted at a clock edge when trig_in is 1, ser_busy is 0 and done is 0. On acceptance pat_data becomes the next state: it shifts one place toward the MSB and the new bit 0 is the XOR of old bits 7, 5, 4 and 3. At every other edge pat_data holds its value.
- R4: Starting from SEED, the sequence visits 255 distinct non-zero values and returns to SEED on the 255th accepted trigger. pat_data is never zero.
- R5: pat_valid is 1 for exactly the one cycle that follows an acceptance. In that cycle pat_data already shows the new byte.
- R6: From the edge of acceptance, ser_out sends a start bit of 0, then the 8 bits of the new byte with bit 0 first, then a stop bit of 1. Each bit lasts BIT_CLKS cycles. When no frame is active the line is 1.
- R7: ser_busy is 1 for exactly 10*BIT_CLKS cycles from the edge of acceptance. Triggers during that time are ignored: pat_data, the count and the serial line do not react to them.
- R8: After PATTERN_COUNT accepted triggers (default 256), done is 1 and stays 1. Later triggers change neither pat_data nor ser_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Request for the next test byte |
| pat_data | output | 8 | Current test byte for the transmitter under test |
| pat_valid | output | 1 | One-cycle strobe marking a new byte |
| ser_out | output | 1 | Framed serial copy of the byte for the receiver under test |
| ser_busy | output | 1 | A frame is being shifted out |
| run_en | output | 1 | Generation is active (low in reset and after completion) |
| done | output | 1 | The pattern budget is exhausted |

## Verification
If the register state is wrong, pat_data shows a wrong byte in the cycle after the faulty step. This is because every step is visible on the bus right away. If the serializer's bit counter or period counter is off, ser_out shows a wrong level, or ser_busy falls on the wrong cycle, within one bit period. If the pattern counter is off, done rises on the wrong acceptance, or a trigger after completion still moves pat_data. The bench's model predicts all outputs every cycle, so any such error is reported in the cycle it first appears.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = BYTE_W + 2;

  // Fibonacci step for x^8+x^6+x^5+x^4+1
  function automatic logic [BYTE_W-1:0] lfsr_step(input logic [BYTE_W-1:0] s);
    return {s[BYTE_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/bpg_lfsr.sv
module bpg_lfsr
  import bpg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SEED = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [BYTE_W-1:0] state_q,
  output logic [BYTE_W-1:0] state_nxt
);
  assign state_nxt = lfsr_step(state_q);

  always_ff @(posedge clk) begin
    if (rst)       state_q <= SEED;
    else if (step) state_q <= state_nxt;
  end

  // R3
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state_q));
  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
endmodule

// File: rtl/bpg_serializer.sv
module bpg_serializer
  import bpg_pkg::*;
#(
  parameter int BIT_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic              line_q,
  output logic              busy_q
);
  localparam int TW = $clog2(BIT_CLKS + 1);
  localparam int IW = $clog2(FRAME_BITS + 1);

  logic [BYTE_W:0] frame_q;
  logic [TW-1:0]   tick_q;
  logic [IW-1:0]   idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '1;
      tick_q  <= '0;
      idx_q   <= '0;
      line_q  <= 1'b1;
      busy_q  <= 1'b0;
    end else if (load) begin
      frame_q <= {1'b1, din};
      tick_q  <= '0;
      idx_q   <= '0;
      line_q  <= 1'b0;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      if (tick_q == TW'(BIT_CLKS - 1)) begin
        tick_q <= '0;
        if (idx_q == IW'(FRAME_BITS - 1)) begin
          busy_q <= 1'b0;
          line_q <= 1'b1;
        end else begin
          line_q  <= frame_q[0];
          frame_q <= {1'b1, frame_q[BYTE_W:1]};
          idx_q   <= idx_q + 1'b1;
        end
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  // R7
  ser_load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy_q);
  // R6
  ser_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> line_q);
  // R6
  ser_start_low_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (busy_q && !line_q));
endmodule

// File: rtl/bpg_counter.sv
module bpg_counter #(
  parameter int PATTERN_COUNT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  output logic done_q
);
  localparam int CW = $clog2(PATTERN_COUNT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(PATTERN_COUNT - 1)) done_q <= 1'b1;
    end
  end

  // R8
  cnt_done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);
  // R8
  cnt_no_inc_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !inc);
endmodule

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen
  import bpg_pkg::*;
#(
  parameter logic [7:0] SEED          = 8'hA5,
  parameter int         BIT_CLKS      = 4,
  parameter int         PATTERN_COUNT = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trig_in,
  output logic [7:0] pat_data,
  output logic       pat_valid,
  output logic       ser_out,
  output logic       ser_busy,
  output logic       run_en,
  output logic       done
);
  logic              accept;
  logic [BYTE_W-1:0] nxt;

  assign accept = trig_in && !ser_busy && !done;

  bpg_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .step(accept),
    .state_q(pat_data), .state_nxt(nxt)
  );

  bpg_serializer #(.BIT_CLKS(BIT_CLKS)) u_ser (
    .clk(clk), .rst(rst), .load(accept), .din(nxt),
    .line_q(ser_out), .busy_q(ser_busy)
  );

  bpg_counter #(.PATTERN_COUNT(PATTERN_COUNT)) u_cnt (
    .clk(clk), .rst(rst), .inc(accept), .done_q(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_valid <= 1'b0;
      run_en    <= 1'b0;
    end else begin
      pat_valid <= accept;
      run_en    <= !done && !(accept && u_cnt.cnt_q == u_cnt.CW'(PATTERN_COUNT - 1));
    end
  end

  // R5
  top_valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    pat_valid |=> !pat_valid);
  // R2
  top_run_vs_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !run_en);
endmodule

// File: tb/bist_pattern_gen_tb.sv
module bist_pattern_gen_tb;
  localparam int B = 4;
  localparam int N = 256;
  localparam logic [7:0] SEED = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_in = 1'b0;
  logic [7:0] pat_data;
  logic pat_valid, ser_out, ser_busy, run_en, done;

  always #4 clk = ~clk;

  bist_pattern_gen #(.SEED(SEED), .BIT_CLKS(B), .PATTERN_COUNT(N)) u_dut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .pat_data(pat_data),
    .pat_valid(pat_valid), .ser_out(ser_out), .ser_busy(ser_busy),
    .run_en(run_en), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] m_pat;
  bit m_valid, m_busy, m_done, m_run;
  int m_elapsed, m_cnt;
  logic [7:0] pats[$];

  function automatic logic [7:0] next_of(logic [7:0] v);
    logic fb;
    fb = v[7] ^ v[5] ^ v[4] ^ v[3];
    return (v << 1) | {7'd0, fb};
  endfunction

  function automatic bit exp_line();
    int b;
    if (!m_busy) return 1'b1;
    b = m_elapsed / B;
    if (b == 0) return 1'b0;
    if (b <= 8) return m_pat[b-1];
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    bit acc;
    if (rst) begin
      m_pat = SEED; m_valid = 0; m_busy = 0; m_done = 0; m_run = 0;
      m_elapsed = 0; m_cnt = 0;
    end else begin
      acc = trig_in && !m_busy && !m_done;
      if (m_busy) begin
        m_elapsed++;
        if (m_elapsed == 10*B) m_busy = 0;
      end
      m_valid = acc;
      if (acc) begin
        m_pat = next_of(m_pat);
        m_busy = 1; m_elapsed = 0; m_cnt++;
        if (m_cnt == N) m_done = 1;
      end
      m_run = !m_done;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk(pat_data == m_pat, "R3 pat_data", pat_data, m_pat);
      chk(pat_valid == m_valid, "R5 pat_valid", pat_valid, m_valid);
      chk(ser_out == exp_line(), "R6 ser_out", ser_out, exp_line());
      chk(ser_busy == m_busy, "R7 ser_busy", ser_busy, m_busy);
      chk(done == m_done, "R8 done", done, m_done);
      chk(run_en == m_run, "R2 run_en", run_en, m_run);
      if (pat_valid) pats.push_back(pat_data);
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] hold;
    bit seen[256];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pat_data == SEED && ser_out && !ser_busy && !pat_valid && !done && !run_en,
        "R1 reset", pat_data, SEED);
    rst = 1'b0;
    // continuous trigger for 20 frames, including triggers while busy (R7)
    trig_in = 1'b1;
    repeat (20 * (10*B + 1)) @(negedge clk);
    // sparse irregular trigger until completion
    for (int c = 0; c < 60000 && !m_done; c++) begin
      @(negedge clk);
      trig_in = ((c % 7) == 0) || ((c % 11) == 3);
    end
    // R8: triggers after completion are ignored
    @(negedge clk);
    hold = pat_data;
    trig_in = 1'b1;
    repeat (50) @(negedge clk);
    chk(pat_data == hold && ser_out && done, "R8 frozen", pat_data, hold);
    trig_in = 1'b0;
    @(negedge clk);
    // R4 sequence properties
    chk(pats.size() == N, "R8 pattern count", pats.size(), N);
    if (pats.size() >= 255) begin
      chk(pats[254] == SEED, "R4 period", pats[254], SEED);
      for (int i = 0; i < 255; i++) begin
        chk(pats[i] != 8'h00 && !seen[pats[i]], "R4 distinct", pats[i], 0);
        seen[pats[i]] = 1;
      end
    end
    report();
  end
endmodule